// File: doc/BRIEF.md
# Supply Threshold Event Controller

This block watches a comparator output that says whether the supply sits above a threshold. It turns crossings of that threshold into one of two outcomes: an interrupt request that stays pending until the CPU acknowledges it, or an internal reset pulse of fixed length. The raw comparator level first passes through a synchronizer. It can then go through an optional digital filter that accepts a new level only after several consecutive sampling pulses agree on it. Edge detection runs on the resulting level.

Software drives the block through one small control word. The word holds two enable bits, a filter switch, a crossing-direction select, an interrupt-or-reset mode select and a sticky detection flag. Software can only clear the flag. A read-back word returns the controls, the flag and the current accepted comparator level. The sampling clock and the low-speed clock are modelled as single-cycle enable pulses on the system clock. The CPU acknowledge is a plain input.

Top module: `vmon_evt_ctrl`

## Requirements
- R1: After reset `rd_data` is all zero. A write (`wr_en`=1) loads the controls from `wr_data[4:0]`: bit 0 detector enable, bit 1 monitor enable, bit 2 filter on, bit 3 falling-direction select, bit 4 reset mode. `rd_data[4:0]` returns these bits, `rd_data[5]` is the detection flag and `rd_data[6]` is the accepted comparator level.
- R2: Unless bits 0 and 1 are both 1, no crossing sets the flag, raises `irq_req` or raises `rst_req`.
- R3: `cmp_raw` passes through SYNC_STAGES flops. With the filter off, a change shows in `rd_data[6]` on the (SYNC_STAGES+1)th rising edge after it is applied, and the resulting crossing sets the flag one edge later.
- R4: With the filter on and the block active, a new level is accepted only on the FILT_SAMPLES-th consecutive `samp_en` pulse that sees it. A pulse that sees the accepted level restarts the count, and without `samp_en` pulses the level never changes.
- R5: With the filter off, bit 3 = 0 detects only upward crossings and bit 3 = 1 detects only downward crossings.
- R6: With the filter on, a change of the accepted level in either direction is a crossing, whatever bit 3 holds.
- R7: A crossing sets the flag. Only a write with `wr_data[5]`=0 clears it, and writing 1 has no effect. When a crossing and a clearing write happen in the same cycle, the flag stays set.
- R8: With bit 4 = 0, a crossing raises `irq_req`. It stays high until a cycle with `irq_ack`=1, which drops it without touching the flag.
- R9: With bit 4 = 1, a crossing raises `rst_req` instead of `irq_req`. `rst_req` stays high until RST_TICKS `lo_tick` pulses have been counted, then falls.
- R10: Once the block is inactive, `irq_req`, `rst_req` and the filter count return to idle within one cycle. The accepted level tracks the synchronized input, so enabling the block again raises no stale crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Control bits [4:0] and flag-clear bit [5] |
| rd_data | output | 7 | Level, flag and control read-back |
| cmp_raw | input | 1 | Asynchronous comparator output, 1 = above threshold |
| samp_en | input | 1 | Filter sampling-clock enable pulse |
| lo_tick | input | 1 | Low-speed clock enable pulse |
| irq_ack | input | 1 | CPU accepted the interrupt |
| irq_req | output | 1 | Pending interrupt request |
| rst_req | output | 1 | Internal reset request |

## Verification
The bench builds the block with SYNC_STAGES=2 and FILT_SAMPLES=3. With these values the synchronizer delay and the three-sample acceptance rule can be checked edge by edge, including a count that restarts after an interrupted run. RST_TICKS is lowered to 5 so that the whole reset pulse can be stepped through `lo_tick` by `lo_tick`, with a check both before and after the release point. The same build reaches the same-cycle conflict between a crossing and a flag clear, and the forced idle state when the block is disabled partway through.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
   typedef struct packed {
      logic mode_rst;
      logic dir_fall;
      logic filt_on;
      logic mon_en;
      logic det_en;
   } vmon_ctl_t;

   localparam int CTL_W    = 5;
   localparam int FLAG_POS = 5;
   localparam int LVL_POS  = 6;
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2 || STAGES > 8) begin : g_bad_stages
      $error("vmon_sync: STAGES must be within 2..8");
   end

   logic [STAGES-1:0] chain;

   genvar i;
   for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else if (i == 0) chain[i] <= d;
         else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/vmon_filter.sv
module vmon_filter #(
   parameter int SAMPLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic filt_on,
   input  logic samp_en,
   input  logic d,
   output logic lvl
);
   if (SAMPLES < 1 || SAMPLES > 255) begin : g_bad_samples
      $error("vmon_filter: SAMPLES must be within 1..255");
   end

   logic gated;
   assign gated = active && filt_on;

   if (SAMPLES == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl <= 1'b0;
         else if (!gated || samp_en) lvl <= d;
      end
   end else begin : g_count
      localparam int CW = $clog2(SAMPLES);
      localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);
      logic [CW-1:0] run;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl <= 1'b0;
            run <= '0;
         end else if (!gated) begin
            lvl <= d;
            run <= '0;
         end else if (samp_en) begin
            if (d == lvl) begin
               run <= '0;
            end else if (run == LAST) begin
               lvl <= d;
               run <= '0;
            end else begin
               run <= run + CW'(1);
            end
         end
      end

      // R10: the count is idle one cycle after the filter is bypassed
      p_run_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !gated |=> (run == '0));
   end

   // R4: while filtering, the level only moves on a sampling pulse
   p_accept_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((lvl != $past(lvl)) && $past(gated)) |-> $past(samp_en));
endmodule

// File: rtl/vmon_rst_timer.sv
module vmon_rst_timer #(
   parameter int TICKS = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic start,
   input  logic tick,
   output logic busy
);
   if (TICKS < 1 || TICKS > 65535) begin : g_bad_ticks
      $error("vmon_rst_timer: TICKS must be within 1..65535");
   end

   localparam int CW = $clog2(TICKS + 1);
   localparam logic [CW-1:0] LOAD = CW'(TICKS);

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) left <= '0;
      else if (!active) left <= '0;
      else if (start) left <= LOAD;
      else if (tick && left != '0) left <= left - CW'(1);
   end

   assign busy = (left != '0);

   // R9: the reset request ends only on a low-speed tick or a disable
   p_release_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(tick) || !$past(active)));
endmodule

// File: rtl/vmon_evt_ctrl.sv
module vmon_evt_ctrl #(
   parameter int SYNC_STAGES  = 2,
   parameter int FILT_SAMPLES = 3,
   parameter int RST_TICKS    = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [5:0] wr_data,
   output logic [6:0] rd_data,
   input  logic       cmp_raw,
   input  logic       samp_en,
   input  logic       lo_tick,
   input  logic       irq_ack,
   output logic       irq_req,
   output logic       rst_req
);
   import vmon_pkg::*;

   vmon_ctl_t ctl;
   logic      flag, prev, lvl, sync_q, active, evt, up, down;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl <= '0;
      else if (wr_en) ctl <= vmon_ctl_t'(wr_data[CTL_W-1:0]);
   end

   assign active = ctl.det_en && ctl.mon_en;

   vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(sync_q)
   );

   vmon_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .active(active), .filt_on(ctl.filt_on),
      .samp_en(samp_en), .d(sync_q), .lvl(lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else prev <= lvl;
   end

   assign up   = lvl && !prev;
   assign down = !lvl && prev;
   always_comb begin
      if (!active) evt = 1'b0;
      else if (ctl.filt_on) evt = up || down;
      else if (ctl.dir_fall) evt = down;
      else evt = up;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else if (evt) flag <= 1'b1;
      else if (wr_en && !wr_data[FLAG_POS]) flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_req <= 1'b0;
      else if (!active) irq_req <= 1'b0;
      else if (evt && !ctl.mode_rst) irq_req <= 1'b1;
      else if (irq_ack) irq_req <= 1'b0;
   end

   vmon_rst_timer #(.TICKS(RST_TICKS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .active(active),
      .start(evt && ctl.mode_rst), .tick(lo_tick), .busy(rst_req)
   );

   assign rd_data = {lvl, flag, ctl};

   // R7: the flag falls only through a software clear with no crossing
   p_flag_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(wr_en && !wr_data[FLAG_POS] && !evt));

   // R2: the flag rises only while both enables were set
   p_flag_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(ctl.det_en && ctl.mon_en));

   // R8: an acknowledge with no new crossing drops the request
   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !evt) |=> !irq_req);

   // R10: nothing stays requested after the block goes inactive
   p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!irq_req && !rst_req));

   // R9: a reset-mode crossing never raises an interrupt
   p_rst_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && ctl.mode_rst && !irq_req) |=> (rst_req && !irq_req));
endmodule

// File: tb/sim_vmon_evt_ctrl.sv
module sim_vmon_evt_ctrl;
   localparam int T_TICKS = 5;
   localparam logic [5:0] C_DET = 6'h01, C_MON = 6'h02, C_FILT = 6'h04,
                          C_FALL = 6'h08, C_RST = 6'h10, C_KEEP = 6'h20;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmp_raw = 1'b0;
   logic samp_en = 1'b0, lo_tick = 1'b0, irq_ack = 1'b0;
   logic [5:0] wr_data = '0;
   logic [6:0] rd_data;
   logic irq_req, rst_req;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   vmon_evt_ctrl #(.SYNC_STAGES(2), .FILT_SAMPLES(3), .RST_TICKS(T_TICKS)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cmp_raw(cmp_raw), .samp_en(samp_en),
      .lo_tick(lo_tick), .irq_ack(irq_ack), .irq_req(irq_req), .rst_req(rst_req)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] d);
      wr_en = 1'b1; wr_data = d; cyc(1); wr_en = 1'b0;
   endtask

   task automatic set_raw(input logic v);
      cmp_raw = v; cyc(4);
   endtask

   task automatic samp();
      samp_en = 1'b1; cyc(1); samp_en = 1'b0;
   endtask

   task automatic tick();
      lo_tick = 1'b1; cyc(1); lo_tick = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      cyc(2); rst_n = 1'b1; cyc(1);
      chk(rd_data == 7'h00, "R1 reset rd_data", rd_data, 0);
      chk(!irq_req && !rst_req, "R1 reset outputs", {irq_req, rst_req}, 0);
   endtask

   task automatic t_regs();
      wr(C_KEEP | 6'h1A);
      chk(rd_data[4:0] == 5'h1A, "R1 control readback", rd_data[4:0], 'h1A);
      chk(rd_data[5] == 1'b0, "R7 write 1 does not set flag", rd_data[5], 0);
      wr(C_KEEP);
   endtask

   task automatic t_gate();
      wr(C_KEEP | C_DET);
      set_raw(1'b1);
      chk(rd_data[6] == 1'b1, "R2 level tracks while inactive", rd_data[6], 1);
      chk(!rd_data[5] && !irq_req, "R2 det only no event", {rd_data[5], irq_req}, 0);
      set_raw(1'b0);
      wr(C_KEEP | C_MON);
      set_raw(1'b1);
      chk(!rd_data[5] && !irq_req, "R2 mon only no event", {rd_data[5], irq_req}, 0);
      set_raw(1'b0);
   endtask

   task automatic t_latency();
      wr(C_KEEP | C_DET | C_MON);
      cmp_raw = 1'b1; cyc(2);
      chk(rd_data[6] == 1'b0, "R3 level not yet visible", rd_data[6], 0);
      cyc(1);
      chk(rd_data[6] == 1'b1, "R3 level visible third edge", rd_data[6], 1);
      chk(rd_data[5] == 1'b0, "R3 flag one edge later", rd_data[5], 0);
      cyc(1);
      chk(rd_data[5] == 1'b1, "R7 flag set by rise", rd_data[5], 1);
      chk(irq_req == 1'b1, "R8 irq raised", irq_req, 1);
      cyc(5);
      chk(irq_req == 1'b1, "R8 irq held", irq_req, 1);
      ack();
      chk(irq_req == 1'b0, "R8 ack clears irq", irq_req, 0);
      chk(rd_data[5] == 1'b1, "R8 ack leaves flag", rd_data[5], 1);
      wr(C_DET | C_MON);
      chk(rd_data[5] == 1'b0, "R7 write 0 clears flag", rd_data[5], 0);
   endtask

   task automatic t_dir();
      set_raw(1'b0);
      chk(!rd_data[5] && !irq_req, "R5 fall ignored in rise mode", rd_data[5], 0);
      wr(C_KEEP | C_DET | C_MON | C_FALL);
      set_raw(1'b1);
      chk(!rd_data[5] && !irq_req, "R5 rise ignored in fall mode", rd_data[5], 0);
      set_raw(1'b0);
      chk(rd_data[5] == 1'b1, "R5 fall detected", rd_data[5], 1);
      ack();
      wr(C_DET | C_MON | C_FALL);
   endtask

   task automatic t_simul();
      wr(C_KEEP | C_DET | C_MON);
      cmp_raw = 1'b1; cyc(3);
      wr(C_DET | C_MON);
      chk(rd_data[5] == 1'b1, "R7 event beats clear", rd_data[5], 1);
      wr(C_DET | C_MON);
      chk(rd_data[5] == 1'b0, "R7 later clear works", rd_data[5], 0);
      ack();
   endtask

   task automatic t_filter();
      wr(C_KEEP | C_DET | C_MON | C_FILT);
      cmp_raw = 1'b0; cyc(10);
      chk(rd_data[6] == 1'b1, "R4 no pulses no change", rd_data[6], 1);
      samp(); samp();
      chk(rd_data[6] == 1'b1, "R4 two samples not enough", rd_data[6], 1);
      cmp_raw = 1'b1; cyc(3); samp();
      cmp_raw = 1'b0; cyc(3); samp(); samp();
      chk(rd_data[6] == 1'b1, "R4 count restarted", rd_data[6], 1);
      samp();
      chk(rd_data[6] == 1'b0, "R4 third sample accepts", rd_data[6], 0);
      cyc(1);
      chk(rd_data[5] == 1'b1, "R6 filtered fall in rise mode", rd_data[5], 1);
      ack(); wr(C_DET | C_MON | C_FILT);
      cmp_raw = 1'b1; cyc(3); samp(); samp(); samp(); cyc(1);
      chk(rd_data[5] == 1'b1 && irq_req, "R6 filtered rise", rd_data[5], 1);
      ack(); wr(C_DET | C_MON);
   endtask

   task automatic t_rst_pulse();
      wr(C_KEEP | C_DET | C_MON | C_RST);
      set_raw(1'b0);
      cmp_raw = 1'b1; cyc(4);
      chk(rst_req == 1'b1, "R9 reset asserted", rst_req, 1);
      chk(irq_req == 1'b0, "R9 no irq in reset mode", irq_req, 0);
      cyc(10);
      chk(rst_req == 1'b1, "R9 held without ticks", rst_req, 1);
      for (int k = 0; k < T_TICKS - 1; k++) tick();
      chk(rst_req == 1'b1, "R9 held before last tick", rst_req, 1);
      tick();
      chk(rst_req == 1'b0, "R9 released after ticks", rst_req, 0);
      wr(C_DET | C_MON | C_RST);
   endtask

   task automatic t_disable();
      set_raw(1'b0);
      cmp_raw = 1'b1; cyc(4);
      chk(rst_req == 1'b1, "R10 reset running", rst_req, 1);
      wr(C_KEEP | C_MON | C_RST); cyc(1);
      chk(rst_req == 1'b0, "R10 disable drops reset", rst_req, 0);
      wr(C_DET | C_MON);
      set_raw(1'b0);
      cmp_raw = 1'b1; cyc(4);
      chk(irq_req == 1'b1, "R10 irq pending", irq_req, 1);
      wr(C_MON); cyc(1);
      chk(irq_req == 1'b0, "R10 disable drops irq", irq_req, 0);
      set_raw(1'b0);
      chk(rd_data[5] == 1'b0, "R2 disabled crossing no flag", rd_data[5], 0);
      wr(C_KEEP | C_DET | C_MON); cyc(5);
      chk(!rd_data[5] && !irq_req, "R10 no stale event", {rd_data[5], irq_req}, 0);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_gate();
      t_latency();
      t_dir();
      t_simul();
      t_filter();
      t_rst_pulse();
      t_disable();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule